// File: doc/BRIEF.md
# Selectable-Pin Interrupt Channel Unit

The unit turns activity on a wide general-purpose input bus into eight separate interrupt requests. Each channel is pointed at any one pin of the bus by its own pin-select field. A 2-bit mode field gives the channel's trigger condition: a rising edge, a falling edge, a low level or a high level. When the condition is met, the channel raises a flag. The flag stays up until software writes a one to that channel's clear strobe. Clearing the flag acknowledges the event and re-arms the channel.

Every pin of the bus passes through a two-stage synchroniser before any channel looks at it. Edges are found by comparing the current synchronised sample of the chosen pin with the sample taken one cycle earlier. Several channels may watch the same pin, each with a different trigger mode. The register file that holds the per-channel fields sits outside this unit. Along with the fields it supplies a strobe that marks any write to a channel's pin-select or mode field. The unit uses that strobe to restart edge detection, so that retargeting a channel cannot report an edge that never happened.

Top module: `pinirq_unit`

## Requirements
- R1: After synchronous reset, every bit of `status` and of `irq` is 0.
- R2: Channel i watches bus pin `ch_pin_sel[i*SEL_W +: SEL_W]`, and any of the NUM_PINS pins may be chosen. Two channels may watch the same pin, each under its own mode.
- R3: Mode 2'b00 (rising edge) sets the flag after a 0-to-1 change of the selected pin. The new pin value is held on `gpio_in` from before clock edge k, and the flag is visible after edge k+2.
- R4: Mode 2'b01 (falling edge) sets the flag after a 1-to-0 change of the selected pin, with the same latency as R3.
- R5: Mode 2'b10 (level low) and mode 2'b11 (level high) set the flag in every cycle in which the synchronised pin is at that level. A clear given while the level is still present leaves the flag at 1.
- R6: A set flag stays at 1 until the channel's clear strobe is sampled high. When no trigger occurs in that cycle, the flag reads 0 after that clock edge.
- R7: If a trigger and a clear strobe for the same channel fall in the same cycle, the flag is 1 after that edge.
- R8: While `ch_enable[i]` is 0, flag i never sets and `irq[i]` is 0. `irq[i]` is 1 exactly when flag i is 1 and the channel is enabled.
- R9: In a cycle where `ch_cfg_wr[i]` is high, no edge is detected on channel i. The next edge comparison starts from the newly selected pin, so switching from a low pin to a high pin in rising mode does not set the flag.
- R10: `status[i]` reports flag i for each channel, and no other channel's activity affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_PINS | Asynchronous general-purpose input bus |
| ch_pin_sel | input | NUM_CH*SEL_W | Pin-select field per channel, channel i at bits i*SEL_W upward |
| ch_mode | input | NUM_CH*2 | Trigger mode per channel: 00 rise, 01 fall, 10 low, 11 high |
| ch_enable | input | NUM_CH | Channel enable per channel |
| ch_cfg_wr | input | NUM_CH | Pulses high for one cycle when a channel's pin-select or mode field is written |
| ch_clear | input | NUM_CH | Write-one-to-clear strobe per channel |
| irq | output | NUM_CH | Interrupt request per channel |
| status | output | NUM_CH | Flag of each channel |

## Verification
Channel 0 is swept across all 32 pins, and a loop raises one pin on each channel in turn. Comparing the whole status vector after each step separates a wrong pin decode or a channel crosstalk from a correct one. Each of the four modes is driven with the transition or level that should fire it, and is also checked against the case that should not. The latency of the rising and falling modes is checked at the exact edge, one cycle before and at the cycle of setting. Clears are placed while a level is still active and on the same edge as a new trigger, which shows the set-wins ordering. A retarget from a low pin to a high pin shows whether the edge history is cleared, and a disabled channel with a toggling pin shows the gating.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    // What one channel sees of its chosen pin in the current cycle
    typedef struct packed {
        logic cur;
        logic prev;
        logic edge_ok;
    } pin_view_t;

    function automatic logic trig_hit(trig_mode_e mode, pin_view_t v);
        logic hit;
        case (mode)
            TRIG_RISE: hit = v.edge_ok &  v.cur & ~v.prev;
            TRIG_FALL: hit = v.edge_ok & ~v.cur &  v.prev;
            TRIG_LOW:  hit = ~v.cur;
            default:   hit =  v.cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/pinirq_chan.sv
module pinirq_chan
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int SEL_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_sync,
    input  logic [SEL_W-1:0]    sel,
    input  trig_mode_e          mode,
    input  logic                en,
    input  logic                cfg_wr,
    input  logic                clr,
    output logic                flag
);
    logic      cur;
    logic      prev_q;
    logic      hist_q;
    pin_view_t view;
    logic      hit;

    assign cur = (int'(sel) < NUM_PINS) ? pins_sync[sel] : 1'b0;

    always_comb begin
        view.cur     = cur;
        view.prev    = prev_q;
        view.edge_ok = hist_q & ~cfg_wr;
        hit          = trig_hit(mode, view);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            hist_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            prev_q <= cur;
            hist_q <= ~cfg_wr;
            if (en && hit)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pinirq_unit.sv
module pinirq_unit
    import pinirq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_PINS = 32,
    localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PINS-1:0]     gpio_in,
    input  logic [NUM_CH*SEL_W-1:0] ch_pin_sel,
    input  logic [NUM_CH*2-1:0]     ch_mode,
    input  logic [NUM_CH-1:0]       ch_enable,
    input  logic [NUM_CH-1:0]       ch_cfg_wr,
    input  logic [NUM_CH-1:0]       ch_clear,
    output logic [NUM_CH-1:0]       irq,
    output logic [NUM_CH-1:0]       status
);
    logic [NUM_PINS-1:0] pins_sync;
    logic [NUM_CH-1:0]   flags;

    pinirq_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (gpio_in),
        .sync_out (pins_sync)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pinirq_chan #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) chan_i (
            .clk       (clk),
            .rst       (rst),
            .pins_sync (pins_sync),
            .sel       (ch_pin_sel[i*SEL_W +: SEL_W]),
            .mode      (trig_mode_e'(ch_mode[2*i +: 2])),
            .en        (ch_enable[i]),
            .cfg_wr    (ch_cfg_wr[i]),
            .clr       (ch_clear[i]),
            .flag      (flags[i])
        );
    end

    assign status = flags;
    assign irq    = flags & ch_enable;
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk #(
    parameter int NUM_CH   = 8,
    parameter int NUM_PINS = 32,
    localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_PINS-1:0]     gpio_in,
    input logic [NUM_CH*SEL_W-1:0] ch_pin_sel,
    input logic [NUM_CH*2-1:0]     ch_mode,
    input logic [NUM_CH-1:0]       ch_enable,
    input logic [NUM_CH-1:0]       ch_cfg_wr,
    input logic [NUM_CH-1:0]       ch_clear,
    input logic [NUM_CH-1:0]       irq,
    input logic [NUM_CH-1:0]       status
);
    logic [2:0]          warm;
    logic [NUM_PINS-1:0] gd1, gd2, gd3, gd4;

    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != 3'd7)
            warm <= warm + 3'd1;
        gd1 <= gpio_in;
        gd2 <= gd1;
        gd3 <= gd2;
        gd4 <= gd3;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [SEL_W-1:0] sel_d1, sel_d2;
        logic [1:0]       mode_d1;
        logic             cfg_d2;

        always_ff @(posedge clk) begin
            sel_d1  <= ch_pin_sel[i*SEL_W +: SEL_W];
            sel_d2  <= sel_d1;
            mode_d1 <= ch_mode[2*i +: 2];
            cfg_d2  <= $past(ch_cfg_wr[i]);
        end

        // R6
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !ch_clear[i]) |=> status[i]);

        // R8
        set_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
            (warm >= 3'd1 && $rose(status[i])) |-> $past(ch_enable[i]));

        // R5
        level_high_cause_chk: assert property (@(posedge clk) disable iff (rst)
            (warm >= 3'd4 && $rose(status[i]) && mode_d1 == 2'b11)
            |-> gd3[sel_d1]);

        // R3
        rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
            (warm >= 3'd5 && $rose(status[i]) && mode_d1 == 2'b00
             && sel_d1 == sel_d2 && !cfg_d2)
            |-> (gd3[sel_d1] && !gd4[sel_d1]));
    end
endmodule

bind pinirq_unit pinirq_chk #(.NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .gpio_in    (gpio_in),
    .ch_pin_sel (ch_pin_sel),
    .ch_mode    (ch_mode),
    .ch_enable  (ch_enable),
    .ch_cfg_wr  (ch_cfg_wr),
    .ch_clear   (ch_clear),
    .irq        (irq),
    .status     (status)
);

// File: tb/pinirq_unit_tb_top.sv
module pinirq_unit_tb_top;
    localparam int NCH = 8;
    localparam int NP  = 32;
    localparam int SW  = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NP-1:0]  gpio = '0;
    logic [NCH*SW-1:0] sel = '0;
    logic [NCH*2-1:0]  mode = '0;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] cfg_wr = '0;
    logic [NCH-1:0] clr = '0;
    logic [NCH-1:0] irq;
    logic [NCH-1:0] status;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pinirq_unit #(.NUM_CH(NCH), .NUM_PINS(NP)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .gpio_in    (gpio),
        .ch_pin_sel (sel),
        .ch_mode    (mode),
        .ch_enable  (en),
        .ch_cfg_wr  (cfg_wr),
        .ch_clear   (clr),
        .irq        (irq),
        .status     (status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cfg(input int ch, input int pin, input logic [1:0] m, input logic e);
        @(negedge clk);
        sel[ch*SW +: SW] = pin[SW-1:0];
        mode[ch*2 +: 2]  = m;
        en[ch]           = e;
        cfg_wr[ch]       = 1'b1;
        @(negedge clk);
        cfg_wr[ch]       = 1'b0;
    endtask

    task automatic pulse_clr(input int ch);
        @(negedge clk);
        clr[ch] = 1'b1;
        @(negedge clk);
        clr[ch] = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(status == '0, "R1 status after reset", 32'(status), 0);
        check(irq == '0, "R1 irq after reset", 32'(irq), 0);

        // R3 rising on channel 0, pin 5, exact latency
        cfg(0, 5, 2'b00, 1'b1);
        wait_cyc(3);
        gpio[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(status[0] == 1'b0, "R3 rise not yet after two edges", 32'(status), 0);
        @(posedge clk); @(negedge clk);
        check(status == 8'h01, "R3 rise sets after third edge", 32'(status), 32'h01);
        check(irq == 8'h01, "R8 irq follows enabled flag", 32'(irq), 32'h01);

        // R6 sticky, then clear
        gpio[5] = 1'b0;
        wait_cyc(6);
        check(status[0] == 1'b1, "R6 flag held after pin drops", 32'(status), 32'h01);
        pulse_clr(0);
        check(status[0] == 1'b0, "R6 clear drops flag", 32'(status), 0);
        wait_cyc(4);
        check(status[0] == 1'b0, "R6 stays clear without event", 32'(status), 0);

        // R7 set wins over clear
        pulse_clr(0);
        gpio[5] = 1'b1;
        wait_cyc(5);
        gpio[5] = 1'b0;
        wait_cyc(5);
        gpio[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        clr[0] = 1'b1;
        @(negedge clk);
        clr[0] = 1'b0;
        check(status[0] == 1'b1, "R7 set wins over same-cycle clear", 32'(status), 1);
        pulse_clr(0);
        check(status[0] == 1'b0, "R7 later clear takes effect", 32'(status), 0);
        gpio[5] = 1'b0;

        // R4 falling on channel 1, pin 31
        gpio[31] = 1'b1;
        wait_cyc(4);
        cfg(1, 31, 2'b01, 1'b1);
        wait_cyc(4);
        check(status[1] == 1'b0, "R4 no event while high", 32'(status), 0);
        gpio[31] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(status[1] == 1'b0, "R4 fall not yet after two edges", 32'(status), 0);
        @(posedge clk); @(negedge clk);
        check(status[1] == 1'b1, "R4 fall sets after third edge", 32'(status), 32'h02);

        // R5 level low on channel 2, pin 0
        cfg(2, 0, 2'b10, 1'b1);
        wait_cyc(4);
        check(status[2] == 1'b1, "R5 level low sets", 32'(status), 32'h04);
        pulse_clr(2);
        check(status[2] == 1'b1, "R5 clear while low keeps flag", 32'(status), 32'h04);
        gpio[0] = 1'b1;
        wait_cyc(4);
        pulse_clr(2);
        check(status[2] == 1'b0, "R5 clear after level gone", 32'(status), 0);

        // R5 level high on channel 3, pin 17
        cfg(3, 17, 2'b11, 1'b1);
        wait_cyc(4);
        check(status[3] == 1'b0, "R5 level high idle", 32'(status), 0);
        gpio[17] = 1'b1;
        wait_cyc(4);
        check(status[3] == 1'b1, "R5 level high sets", 32'(status), 32'h08);
        pulse_clr(3);
        check(status[3] == 1'b1, "R5 clear while high keeps flag", 32'(status), 32'h08);
        gpio[17] = 1'b0;
        wait_cyc(4);
        pulse_clr(3);
        check(status[3] == 1'b0, "R5 clear after high gone", 32'(status), 0);

        // R8 disabled channel 4 on pin 9
        cfg(4, 9, 2'b00, 1'b0);
        gpio[9] = 1'b1;
        wait_cyc(5);
        gpio[9] = 1'b0;
        wait_cyc(5);
        check(status[4] == 1'b0, "R8 disabled channel never sets", 32'(status), 0);
        check(irq[4] == 1'b0, "R8 disabled channel irq low", 32'(irq), 0);

        // R9 retarget low pin to high pin in rising mode
        gpio[11] = 1'b1;
        cfg(5, 10, 2'b00, 1'b1);
        wait_cyc(4);
        cfg(5, 11, 2'b00, 1'b1);
        wait_cyc(5);
        check(status[5] == 1'b0, "R9 retarget gives no false edge", 32'(status), 0);
        gpio[11] = 1'b0;
        wait_cyc(4);
        gpio[11] = 1'b1;
        wait_cyc(4);
        check(status[5] == 1'b1, "R9 channel works after retarget", 32'(status), 32'h20);
        gpio[11] = 1'b0;

        // R2 two channels sharing pin 20
        cfg(6, 20, 2'b00, 1'b1);
        cfg(7, 20, 2'b01, 1'b1);
        wait_cyc(4);
        gpio[20] = 1'b1;
        wait_cyc(4);
        check(status[7:6] == 2'b01, "R2 shared pin rise", 32'(status[7:6]), 1);
        gpio[20] = 1'b0;
        wait_cyc(4);
        check(status[7:6] == 2'b11, "R2 shared pin fall", 32'(status[7:6]), 3);

        // quiesce all channels
        for (int c = 0; c < NCH; c++) begin
            cfg(c, 0, 2'b00, 1'b0);
            pulse_clr(c);
        end
        gpio = '0;
        wait_cyc(4);
        check(status == '0 && irq == '0, "R10 all quiet", 32'(status), 0);

        // R2 pin sweep on channel 0
        for (int p = 0; p < NP; p++) begin
            cfg(0, p, 2'b00, 1'b1);
            wait_cyc(3);
            gpio[p] = 1'b1;
            wait_cyc(4);
            check(status == 8'h01, $sformatf("R2 sweep pin %0d", p), 32'(status), 1);
            gpio[p] = 1'b0;
            wait_cyc(4);
            pulse_clr(0);
            check(status == '0, $sformatf("R6 sweep clear pin %0d", p), 32'(status), 0);
        end
        cfg(0, 0, 2'b00, 1'b0);

        // R10 per-channel isolation
        for (int c = 0; c < NCH; c++) begin
            int pin;
            pin = (c * 5 + 3) % NP;
            cfg(c, pin, 2'b00, 1'b1);
            wait_cyc(3);
            gpio[pin] = 1'b1;
            wait_cyc(4);
            check(status == NCH'(1 << c), $sformatf("R10 channel %0d alone", c),
                  32'(status), 32'(1 << c));
            check(irq == NCH'(1 << c), $sformatf("R8 irq channel %0d", c),
                  32'(irq), 32'(1 << c));
            gpio[pin] = 1'b0;
            cfg(c, pin, 2'b00, 1'b0);
            pulse_clr(c);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule